// File: doc/BRIEF.md
# Memory Clock and Clock-Enable Controller

This block produces the clocks and clock enables for the synchronous devices on a memory bus. There are three clock outputs. Lane 0 feeds a synchronous mask ROM in the boot bank, lane 1 feeds SDRAM banks 0/1, and lane 2 feeds SDRAM banks 2/3. All three lanes come from one free-running counter that runs on the CPU clock `clk`. Each lane runs at one of two rates: a fast rate of `clk`/2 or a slow rate of `clk`/4. A lane can also be switched off. Two clock-enable outputs serve the ROM (enable 0) and the SDRAM (enable 1).

A one-bit strap tells the block whether the boot bank is a synchronous ROM. The strap is captured on the first clock after reset and is read-only after that. While the ROM mode is active, software cannot switch off lane 0 and cannot drop enable 0. A sleep request silences every output. The only way out of sleep is a reset, and every reset, including a sleep exit, restores the defaults.

Software reaches the settings through a small synchronous port with address, write data, write enable and registered read data. A new rate or enable setting takes effect only at the wrap of the shared counter, which is the common period boundary of both rates. Because of this, no shortened pulse ever reaches a memory device.

Top module: `memclk_ctrl`

## Requirements
- R1: A lane at the fast rate is high for one `clk` cycle and low for the next. A lane at the slow rate is high for two cycles and low for two.
- R2: After reset, every lane runs at the slow rate with its disable bit clear, and address 0 reads 0x00.
- R3: Address 0 holds the rate bits in [2:0] (1 = fast, lane n at bit n) and the disable bits in [6:4] (lane n at bit 4+n). Read data appears one cycle after the address is presented and shows the effective settings.
- R4: A lane whose disable bit is set stays low.
- R5: While the ROM mode is active, the disable bit of lane 0 has no effect, lane 0 keeps running, and bit 4 of address 0 reads 0.
- R6: The strap is sampled on the first clock after reset. Its value reads as bit 0 of address 2. Writes to address 2 are ignored.
- R7: Within two cycles after reset, enable 0 equals the sampled ROM mode and enable 1 is low.
- R8: Address 1 bits [1:0] hold the enable request for enables 0 and 1 (1 = asserted). While the ROM mode is active, enable 0 stays asserted even when its bit is written 0.
- R9: If `sleep_req` is high at a rising edge, all clocks and enables are low from the second following edge on. They stay low until reset, and bit 1 of address 2 reads 1.
- R10: Rate and enable changes take effect only at the counter wrap. No high phase lasts more than two cycles, and none is cut short.
- R11: All lanes share one phase reference, so lanes set to the same rate toggle together, and no lane rises in the cycle where the counter reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, also used for sleep exit |
| rom_strap | input | 1 | Boot bank is a synchronous ROM (sampled after reset) |
| sleep_req | input | 1 | Sleep entry request |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Registered read data |
| mclk_out | output | 3 | Memory clocks: lane 0 ROM, lanes 1 and 2 SDRAM pairs |
| mcke_out | output | 2 | Clock enables: 0 ROM, 1 SDRAM |

## Verification
The bound checker watches these rules on every cycle:
- No clock holds high for more than two cycles.
- No clock rises in the cycle where the counter reads 1.
- Sleep silences every output two edges after the request.
- The ROM enable stays up while the ROM mode is active.
- The SDRAM enable stays low unless it is requested.

Some behaviour is visible only through the bench's scenarios, which look at the ports:
- The actual rate of each lane.
- The lock on lane 0 and on enable 0 while the ROM mode is active.
- The reset defaults under both strap values.
- The register read-back and the ignored status writes.
- The random mixes of rate, disable and enable settings.

// File: rtl/memclk_pkg.sv
`timescale 1ns/1ps
package memclk_pkg;
   localparam int unsigned PH_W  = 2;
   localparam int unsigned CKE_N = 2;
   typedef enum logic [1:0] {
      SEL_CLK  = 2'd0,
      SEL_CKE  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/memclk_phase.sv
`timescale 1ns/1ps
module memclk_phase
   import memclk_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] ph,
   output logic            wrap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= '0;
      else        ph <= ph + 1'b1;
   end

   // Counter wrap: the last cycle of a slow period, which is also the end of a fast period
   always_comb wrap = (ph == {PH_W{1'b1}});
endmodule

// File: rtl/memclk_lane.sv
`timescale 1ns/1ps
module memclk_lane
   import memclk_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PH_W-1:0] ph,
   input  logic            wrap,
   input  logic            asleep,
   input  logic            want_en,
   input  logic            want_fast,
   output logic            clk_o
);
   logic en_c;
   logic fast_c;
   logic src;

   always_comb src = fast_c ? ph[0] : ph[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_c   <= 1'b1;
         fast_c <= 1'b0;
         clk_o  <= 1'b0;
      end else begin
         if (wrap) begin
            en_c   <= want_en;
            fast_c <= want_fast;
         end
         clk_o <= ~asleep & en_c & src;
      end
   end
endmodule

// File: rtl/memclk_regs.sv
`timescale 1ns/1ps
module memclk_regs
   import memclk_pkg::*;
#(
   parameter int unsigned NUM_CLK = 3,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rom_strap,
   input  logic               sleep_req,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               we,
   output logic [DATA_W-1:0]  rdata,
   output logic [NUM_CLK-1:0] lane_en,
   output logic [NUM_CLK-1:0] lane_fast,
   output logic [CKE_N-1:0]   cke_want,
   output logic [CKE_N-1:0]   cke_o,
   output logic               rom_en,
   output logic               asleep
);
   localparam int unsigned DIS_LSB = DATA_W / 2;

   logic               run;
   logic [NUM_CLK-1:0] fast_r;
   logic [NUM_CLK-1:0] dis_r;
   logic [NUM_CLK-1:0] dis_eff;
   logic [CKE_N-1:0]   cke_r;
   logic [DATA_W-1:0]  rd_nxt;

   if (NUM_CLK > DIS_LSB) begin : g_bad_w
      $error("memclk_regs: NUM_CLK does not fit in half of DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_a
      $error("memclk_regs: ADDR_W must be at least 2");
   end

   // Lane 0 is the ROM clock and alone carries the lock
   for (genvar i = 0; i < NUM_CLK; i++) begin : g_dis
      if (i == 0) begin : g_rom
         always_comb dis_eff[i] = dis_r[i] & ~rom_en;
      end else begin : g_ram
         always_comb dis_eff[i] = dis_r[i];
      end
   end

   always_comb begin
      lane_en   = ~dis_eff;
      lane_fast = fast_r;
      cke_want  = cke_r;
      cke_want[0] = cke_r[0] | rom_en;
   end

   always_comb begin
      rd_nxt = '0;
      unique case (addr)
         ADDR_W'(SEL_CLK): begin
            rd_nxt[NUM_CLK-1:0]         = fast_r;
            rd_nxt[DIS_LSB +: NUM_CLK]  = dis_eff;
         end
         ADDR_W'(SEL_CKE):  rd_nxt[CKE_N-1:0] = cke_want;
         ADDR_W'(SEL_STAT): rd_nxt[1:0] = {asleep, rom_en};
         default:           rd_nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         rom_en <= 1'b0;
         fast_r <= '0;
         dis_r  <= '0;
         cke_r  <= '0;
         asleep <= 1'b0;
         cke_o  <= '0;
         rdata  <= '0;
      end else begin
         if (!run) begin
            run    <= 1'b1;
            rom_en <= rom_strap;
         end
         asleep <= asleep | sleep_req;
         if (we && addr == ADDR_W'(SEL_CLK)) begin
            fast_r <= wdata[NUM_CLK-1:0];
            dis_r  <= wdata[DIS_LSB +: NUM_CLK];
         end
         if (we && addr == ADDR_W'(SEL_CKE)) cke_r <= wdata[CKE_N-1:0];
         cke_o <= asleep ? '0 : cke_want;
         rdata <= rd_nxt;
      end
   end
endmodule

// File: rtl/memclk_ctrl.sv
`timescale 1ns/1ps
module memclk_ctrl
   import memclk_pkg::*;
#(
   parameter int unsigned NUM_CLK = 3,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rom_strap,
   input  logic               sleep_req,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_we,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [NUM_CLK-1:0] mclk_out,
   output logic [CKE_N-1:0]   mcke_out
);
   logic [PH_W-1:0]    ph_w;
   logic               wrap_w;
   logic [NUM_CLK-1:0] lane_en_w;
   logic [NUM_CLK-1:0] lane_fast_w;
   logic [CKE_N-1:0]   cke_want_w;
   logic               rom_en_w;
   logic               asleep_w;

   if (NUM_CLK < 1) begin : g_bad_n
      $error("memclk_ctrl: NUM_CLK must be at least 1");
   end

   memclk_phase u_phase (
      .clk (clk),
      .rst_n (rst_n),
      .ph (ph_w),
      .wrap (wrap_w)
   );

   memclk_regs #(
      .NUM_CLK (NUM_CLK),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk (clk),
      .rst_n (rst_n),
      .rom_strap (rom_strap),
      .sleep_req (sleep_req),
      .addr (reg_addr),
      .wdata (reg_wdata),
      .we (reg_we),
      .rdata (reg_rdata),
      .lane_en (lane_en_w),
      .lane_fast (lane_fast_w),
      .cke_want (cke_want_w),
      .cke_o (mcke_out),
      .rom_en (rom_en_w),
      .asleep (asleep_w)
   );

   for (genvar i = 0; i < NUM_CLK; i++) begin : g_lane
      memclk_lane u_lane (
         .clk (clk),
         .rst_n (rst_n),
         .ph (ph_w),
         .wrap (wrap_w),
         .asleep (asleep_w),
         .want_en (lane_en_w[i]),
         .want_fast (lane_fast_w[i]),
         .clk_o (mclk_out[i])
      );
   end
endmodule

// File: rtl/memclk_chk.sv
`timescale 1ns/1ps
module memclk_chk
   import memclk_pkg::*;
#(
   parameter int unsigned NUM_CLK = 3
)(
   input logic               clk,
   input logic               rst_n,
   input logic               sleep_req,
   input logic [NUM_CLK-1:0] mclk_out,
   input logic [CKE_N-1:0]   mcke_out,
   input logic               rom_en,
   input logic               asleep,
   input logic [CKE_N-1:0]   cke_want,
   input logic [PH_W-1:0]    ph
);
   for (genvar i = 0; i < NUM_CLK; i++) begin : g_chk
      assert_no_long_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (mclk_out[i] && $past(mclk_out[i])) |=> !mclk_out[i]);
      assert_rise_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mclk_out[i]) |-> (ph != 2'b01));
   end

   assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sleep_req) |=> (mclk_out == '0 && mcke_out == '0));

   assert_rom_cke_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_en && !asleep) |=> mcke_out[0]);

   assert_ram_cke_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_want[1] |=> !mcke_out[1]);
endmodule

bind memclk_ctrl memclk_chk #(.NUM_CLK(NUM_CLK)) u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .sleep_req (sleep_req),
   .mclk_out (mclk_out),
   .mcke_out (mcke_out),
   .rom_en (rom_en_w),
   .asleep (asleep_w),
   .cke_want (cke_want_w),
   .ph (ph_w)
);

// File: tb/tb_memclk_ctrl.sv
`timescale 1ns/1ps
module tb_memclk_ctrl;
   localparam int NCLK = 3;
   localparam int WIN  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rom_strap = 1'b0;
   logic       sleep_req = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_rdata;
   logic [2:0] mclk_out;
   logic [1:0] mcke_out;

   int checks = 0;
   int errors = 0;
   int mon_err = 0;
   int hi_run [NCLK];
   bit done = 0;

   always #10 clk = ~clk;

   memclk_ctrl dut (
      .clk (clk), .rst_n (rst_n), .rom_strap (rom_strap), .sleep_req (sleep_req),
      .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_we (reg_we),
      .reg_rdata (reg_rdata), .mclk_out (mclk_out), .mcke_out (mcke_out)
   );

   // R10 monitor: high phase never longer than two cycles
   always @(negedge clk) begin
      for (int i = 0; i < NCLK; i++) begin
         if (!rst_n || !mclk_out[i]) hi_run[i] = 0;
         else begin
            hi_run[i] = hi_run[i] + 1;
            if (hi_run[i] > 2) mon_err = mon_err + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input bit strap);
      @(negedge clk);
      rst_n = 1'b0; rom_strap = strap; sleep_req = 1'b0; reg_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
   endtask

   // mode codes: 0 off, 1 slow, 2 fast, 3 malformed
   function automatic int exp_mode(input int i, input logic [7:0] ctl, input bit rom);
      bit dis;
      dis = ctl[4+i] && !(i == 0 && rom);
      if (dis) return 0;
      return ctl[i] ? 2 : 1;
   endfunction

   function automatic logic [7:0] exp_ctl_rd(input logic [7:0] ctl, input bit rom);
      logic [7:0] v;
      v = ctl & 8'h77;
      if (rom) v[4] = 1'b0;
      return v;
   endfunction

   function automatic logic [1:0] exp_cke(input logic [1:0] c, input bit rom);
      return {c[1], c[0] | rom};
   endfunction

   task automatic observe(output int mode [NCLK], output logic [WIN-1:0] trace [NCLK]);
      for (int t = 0; t < WIN; t++) begin
         @(negedge clk);
         for (int i = 0; i < NCLK; i++) trace[i][t] = mclk_out[i];
      end
      for (int i = 0; i < NCLK; i++) begin
         bit fast_ok, slow_ok;
         fast_ok = 1; slow_ok = ($countones(trace[i]) == WIN/2);
         for (int t = 1; t < WIN; t++) if (trace[i][t] == trace[i][t-1]) fast_ok = 0;
         for (int t = 2; t < WIN; t++) if (trace[i][t] == trace[i][t-2]) slow_ok = 0;
         if (trace[i] == '0) mode[i] = 0;
         else if (fast_ok) mode[i] = 2;
         else if (slow_ok) mode[i] = 1;
         else mode[i] = 3;
      end
   endtask

   task automatic check_lanes(input logic [7:0] ctl, input bit rom, input string tag);
      int m [NCLK];
      logic [WIN-1:0] tr [NCLK];
      repeat (8) @(negedge clk);
      observe(m, tr);
      for (int i = 0; i < NCLK; i++)
         chk(m[i] == exp_mode(i, ctl, rom), tag, m[i], exp_mode(i, ctl, rom));
      // R11: lanes at the same rate run in phase
      for (int i = 1; i < NCLK; i++)
         if (m[i] != 0 && m[i] == m[0])
            chk(tr[i] == tr[0], "R11 phase", int'(tr[i]), int'(tr[0]));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int unsigned sd;
      bit rom;
      logic [7:0] ctl;
      logic [1:0] ck;
      sd = $urandom(32'd4711);

      // R2, R7: reset defaults without ROM mode
      do_reset(1'b0);
      chk(mcke_out == 2'b00, "R7 cke after reset", mcke_out, 0);
      rd(2'd0, d);
      chk(d == 8'h00, "R2 ctrl reset", d, 0);
      check_lanes(8'h00, 1'b0, "R2 R1 default slow");
      rd(2'd2, d);
      chk(d == 8'h00, "R6 status strap0", d, 0);

      // R1, R3: one lane fast
      wr(2'd0, 8'h02);
      check_lanes(8'h02, 1'b0, "R1 R3 mixed rates");
      rd(2'd0, d);
      chk(d == 8'h02, "R3 readback", d, 8'h02);

      // R4: lane 0 off without ROM mode
      wr(2'd0, 8'h13);
      check_lanes(8'h13, 1'b0, "R4 lane0 disabled");
      rd(2'd0, d);
      chk(d == 8'h13, "R3 readback dis", d, 8'h13);

      // R8: enables under software control
      wr(2'd1, 8'h03);
      repeat (2) @(negedge clk);
      chk(mcke_out == 2'b11, "R8 cke on", mcke_out, 3);
      wr(2'd1, 8'h00);
      repeat (2) @(negedge clk);
      chk(mcke_out == 2'b00, "R8 cke off", mcke_out, 0);

      // R5, R6, R7: ROM mode
      do_reset(1'b1);
      chk(mcke_out == 2'b01, "R7 cke rom", mcke_out, 1);
      rd(2'd2, d);
      chk(d == 8'h01, "R6 status strap1", d, 1);
      wr(2'd2, 8'h00);
      rd(2'd2, d);
      chk(d == 8'h01, "R6 status write ignored", d, 1);
      wr(2'd0, 8'h70);
      check_lanes(8'h70, 1'b1, "R5 lane0 locked");
      rd(2'd0, d);
      chk(d == 8'h60, "R5 readback lock", d, 8'h60);
      wr(2'd1, 8'h00);
      repeat (2) @(negedge clk);
      chk(mcke_out == 2'b01, "R8 cke0 locked", mcke_out, 1);

      // R9: sleep entry holds everything low until reset
      wr(2'd1, 8'h03);
      wr(2'd0, 8'h07);
      repeat (8) @(negedge clk);
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      @(negedge clk);
      chk(mclk_out == 3'b000 && mcke_out == 2'b00, "R9 sleep quiet", {mclk_out, mcke_out}, 0);
      begin
         bit quiet = 1;
         for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (mclk_out != 0 || mcke_out != 0) quiet = 0;
         end
         chk(quiet, "R9 sleep held", quiet, 1);
      end
      rd(2'd2, d);
      chk(d == 8'h03, "R9 status asleep", d, 3);
      do_reset(1'b0);
      chk(mcke_out == 2'b00, "R9 R7 exit defaults", mcke_out, 0);
      check_lanes(8'h00, 1'b0, "R9 R2 exit slow");

      // Random mixes
      rom = 1'b0;
      for (int it = 0; it < 24; it++) begin
         if (it % 6 == 0) begin
            rom = 1'($urandom);
            do_reset(rom);
         end
         ctl = 8'($urandom) & 8'h77;
         ck  = 2'($urandom);
         wr(2'd0, ctl);
         wr(2'd1, {6'd0, ck});
         check_lanes(ctl, rom, "R1 R4 R5 random lanes");
         chk(mcke_out == exp_cke(ck, rom), "R8 random cke", mcke_out, exp_cke(ck, rom));
         rd(2'd0, d);
         chk(d == exp_ctl_rd(ctl, rom), "R3 random readback", d, exp_ctl_rd(ctl, rom));
      end

      chk(mon_err == 0, "R10 high phase length", mon_err, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule